// File: doc/BRIEF.md
# Eight-Region Memory Protection Checker

This block decides, in a single combinational pass, whether one memory access may proceed. It receives an address, the kind of access (instruction fetch, data read or data write), the privilege level of the requester and a global enable. It also receives the contents of eight region registers and two permission words, one for instruction fetches and one for data accesses. It reports whether the matched region may be read and written at the given privilege, and it returns a 2-bit fault code. The physical address output is always the input address, because no translation takes place.

Each region register holds an enable, a size code and a base. A region with size code N covers 2^(N+1) bytes aligned on that size. When regions overlap, the highest-numbered enabled region that matches decides the outcome. An address that no enabled region covers raises a background fault. This fault is separate from a permission fault, so a fault handler can tell a hole in the map apart from a rights violation.

The block has no state. A pipeline places it between address generation and the memory request, and it registers the outputs as its own timing needs.

Top module: `mpc_checker`

## Requirements
- R1: When `enable_i` is 0, every access gives `rd_ok_o`=1, `wr_ok_o`=1 and `fault_o`=2'b00, whatever the region and permission inputs are.
- R2: `paddr_o` equals `addr_i` for every input combination, whether or not the checker is enabled.
- R3: Region register n is bits [32n+31:32n] of `region_cfg_i`. Its bit 0 enables the region and bits [5:1] hold the size code N. The region matches an address when the address and the register agree in every bit above the low N+1 bits. A disabled region never matches.
- R4: A size code of 31 makes the region match every 32-bit address.
- R5: When several enabled regions match, the region with the highest index supplies the permission code.
- R6: When the checker is enabled and no enabled region matches, `fault_o` is 2'b10 and both `rd_ok_o` and `wr_ok_o` are 0.
- R7: The permission code of region n is bits [4n+3:4n] of a permission word. `acc_i`=2'b00 (fetch) takes it from `iperm_i`. `acc_i`=2'b01 (read), 2'b10 (write) and 2'b11 (also treated as a write) take it from `dperm_i`.
- R8: With `priv_i`=1 (privileged) and `priv_i`=0 (user), the rights granted for each code are: 0 none/none; 1 read-write/none; 2 read-write/read; 3 read-write/read-write; 5 read/none; 6 read/read. Any other code grants no rights. `rd_ok_o` and `wr_ok_o` report these rights for the matched region.
- R9: For a matched region, a write without the write right, or a fetch or read without the read right, gives `fault_o`=2'b01.
- R10: For a matched region, an access that holds the needed right gives `fault_o`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 32 | Address of the access |
| acc_i | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 write |
| priv_i | input | 1 | 1 for privileged, 0 for user |
| enable_i | input | 1 | 1 turns protection on |
| region_cfg_i | input | 256 | Eight region registers; region n at bits [32n+31:32n] |
| dperm_i | input | 32 | Data permission word, 4 bits per region |
| iperm_i | input | 32 | Instruction permission word, 4 bits per region |
| paddr_o | output | 32 | Outgoing address, equal to addr_i |
| rd_ok_o | output | 1 | Read right for the matched region at this privilege |
| wr_ok_o | output | 1 | Write right for the matched region at this privilege |
| fault_o | output | 2 | 00 none, 01 permission, 10 background |

## Verification
The immediate assertions assume that every input is driven to a known value. Each check is skipped while any input holds X or Z, so the only input the assertions rely on is a fully resolved vector. The bench drives every port from time zero and changes inputs only away from sampling points. It covers every permission code with both privilege levels and all four access kinds, aligned region edges, size codes 0 and 31, and nested overlapping maps with generated addresses and configurations.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int ADDR_W      = 32;
    localparam int NUM_REGIONS = 8;
    localparam int PERM_W      = 4;
    localparam int SIZE_W      = 5;
    localparam int IDX_W       = $clog2(NUM_REGIONS);

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_WRALT = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_PERM  = 2'b01,
        FLT_BKGND = 2'b10
    } fault_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } rights_t;

endpackage

// File: rtl/mpc_region_match.sv
module mpc_region_match #(
    parameter int AW     = 32,
    parameter int SIZE_W = 5
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] cfg_i,
    output logic          hit_o
);
    localparam int MW = AW + 1;

    logic [SIZE_W-1:0] size_code;
    logic [MW-1:0]     wide_mask;
    logic [AW-1:0]     low_mask;
    logic              enabled;

    always_comb begin
        enabled   = cfg_i[0];
        size_code = cfg_i[SIZE_W:1];
        // One extra bit keeps the shift in range when the code selects the whole space.
        wide_mask = (MW'(1) << (MW'(size_code) + MW'(1))) - MW'(1);
        low_mask  = wide_mask[AW-1:0];
        hit_o     = enabled && (((addr_i ^ cfg_i) & ~low_mask) == '0);
    end

    always_comb begin
        if (!$isunknown({addr_i, cfg_i})) begin
            AST_DISABLED_NO_HIT: assert (cfg_i[0] || !hit_o); // R3
            AST_FULL_SPAN_HIT: assert (!(cfg_i[0] && cfg_i[SIZE_W:1] == '1 && AW == 32) || hit_o); // R4
        end
    end

endmodule

// File: rtl/mpc_prio_select.sv
module mpc_prio_select #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     hit_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < N; k++) begin
            if (hit_i[k]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(k);
            end
        end
    end

    always_comb begin
        if (!$isunknown(hit_i)) begin
            AST_FOUND_IFF_ANY: assert (found_o == (hit_i != '0)); // R6
            AST_SEL_IS_HIT: assert (!found_o || hit_i[idx_o]); // R5
            AST_NONE_ABOVE: assert (!found_o || ((hit_i >> idx_o) >> 1) == '0); // R5
        end
    end

endmodule

// File: rtl/mpc_perm_decode.sv
module mpc_perm_decode
    import mpc_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic [PW-1:0] code_i,
    input  logic          priv_i,
    output rights_t       rights_o
);
    rights_t priv_r, user_r;

    always_comb begin
        priv_r = '{rd: 1'b0, wr: 1'b0};
        user_r = '{rd: 1'b0, wr: 1'b0};
        unique case (code_i)
            PW'(1): priv_r = '{rd: 1'b1, wr: 1'b1};
            PW'(2): begin
                priv_r = '{rd: 1'b1, wr: 1'b1};
                user_r = '{rd: 1'b1, wr: 1'b0};
            end
            PW'(3): begin
                priv_r = '{rd: 1'b1, wr: 1'b1};
                user_r = '{rd: 1'b1, wr: 1'b1};
            end
            PW'(5): priv_r = '{rd: 1'b1, wr: 1'b0};
            PW'(6): begin
                priv_r = '{rd: 1'b1, wr: 1'b0};
                user_r = '{rd: 1'b1, wr: 1'b0};
            end
            default: ;
        endcase
        rights_o = priv_i ? priv_r : user_r;
    end

    always_comb begin
        if (!$isunknown({code_i, priv_i})) begin
            AST_WRITE_IMPLIES_READ: assert (!rights_o.wr || rights_o.rd); // R8
            AST_USER_NOT_ABOVE_PRIV: assert (priv_i || !rights_o.rd || priv_r.rd); // R8
        end
    end

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker
    import mpc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REGIONS,
    parameter int PW = PERM_W
) (
    input  logic [AW-1:0]    addr_i,
    input  logic [1:0]       acc_i,
    input  logic             priv_i,
    input  logic             enable_i,
    input  logic [NR*AW-1:0] region_cfg_i,
    input  logic [NR*PW-1:0] dperm_i,
    input  logic [NR*PW-1:0] iperm_i,
    output logic [AW-1:0]    paddr_o,
    output logic             rd_ok_o,
    output logic             wr_ok_o,
    output logic [1:0]       fault_o
);
    localparam int IW = (NR > 1) ? $clog2(NR) : 1;

    logic [NR-1:0]    hit;
    logic             found;
    logic [IW-1:0]    sel;
    logic [NR*PW-1:0] perm_word;
    logic [PW-1:0]    code;
    rights_t          rights;
    acc_e             acc;
    fault_e           fault;
    logic             need_write;
    logic             granted;

    for (genvar g = 0; g < NR; g++) begin : g_region
        mpc_region_match #(.AW(AW), .SIZE_W(SIZE_W)) match_i (
            .addr_i (addr_i),
            .cfg_i  (region_cfg_i[g*AW +: AW]),
            .hit_o  (hit[g])
        );
    end

    mpc_prio_select #(.N(NR), .IDX_W(IW)) prio_i (
        .hit_i   (hit),
        .found_o (found),
        .idx_o   (sel)
    );

    always_comb begin
        acc       = acc_e'(acc_i);
        perm_word = (acc == ACC_FETCH) ? iperm_i : dperm_i;
        code      = perm_word[sel*PW +: PW];
    end

    mpc_perm_decode #(.PW(PW)) perm_i (
        .code_i   (code),
        .priv_i   (priv_i),
        .rights_o (rights)
    );

    always_comb begin
        need_write = (acc == ACC_WRITE) || (acc == ACC_WRALT);
        granted    = need_write ? rights.wr : rights.rd;
        if (!enable_i) begin
            rd_ok_o = 1'b1;
            wr_ok_o = 1'b1;
            fault   = FLT_NONE;
        end else if (!found) begin
            rd_ok_o = 1'b0;
            wr_ok_o = 1'b0;
            fault   = FLT_BKGND;
        end else begin
            rd_ok_o = rights.rd;
            wr_ok_o = rights.wr;
            fault   = granted ? FLT_NONE : FLT_PERM;
        end
        fault_o = fault;
        paddr_o = addr_i;
    end

    always_comb begin
        if (!$isunknown({addr_i, acc_i, priv_i, enable_i, region_cfg_i, dperm_i, iperm_i})) begin
            AST_OFF_OPEN: assert (enable_i || (rd_ok_o && wr_ok_o && fault_o == 2'b00)); // R1
            AST_ADDR_PASS: assert (paddr_o == addr_i); // R2
            AST_BKGND_CLOSED: assert (fault_o != 2'b10 || (!rd_ok_o && !wr_ok_o)); // R6
            AST_NO_FAULT_GRANTED: assert (!enable_i || fault_o != 2'b00 || (acc_i[1] ? wr_ok_o : rd_ok_o)); // R10
            AST_FAULT_CODE_LEGAL: assert (fault_o != 2'b11); // R9
        end
    end

endmodule

// File: tb/mpc_checker_tb.sv
module mpc_checker_tb_top;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  acc = '0;
    logic        priv = 1'b0;
    logic        en = 1'b0;
    logic [31:0] rg [NR];
    logic [NR*32-1:0] cfg_flat;
    logic [31:0] dperm = '0, iperm = '0;
    logic [31:0] paddr;
    logic        rd_ok, wr_ok;
    logic [1:0]  fault;
    int          checks = 0, failures = 0;
    logic [31:0] lfsr = 32'h1ace_b00c;

    always #10 clk = ~clk;

    always_comb for (int n = 0; n < NR; n++) cfg_flat[n*32 +: 32] = rg[n];

    mpc_checker dut_i (
        .addr_i(addr), .acc_i(acc), .priv_i(priv), .enable_i(en),
        .region_cfg_i(cfg_flat), .dperm_i(dperm), .iperm_i(iperm),
        .paddr_o(paddr), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .fault_o(fault)
    );

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // Expected outputs from the requirement text.
    task automatic model(output logic e_rd, output logic e_wr, output logic [1:0] e_f);
        int          h;
        logic [63:0] a64, b64;
        int          sh;
        logic [31:0] w;
        logic [3:0]  c;
        logic        pr, pw, ur, uw, need;
        if (!en) begin e_rd = 1; e_wr = 1; e_f = 2'b00; return; end  // R1
        h = -1;
        for (int n = NR - 1; n >= 0; n--) begin                        // R5
            sh  = int'(rg[n][5:1]) + 1;
            a64 = {32'b0, addr} >> sh;
            b64 = {32'b0, rg[n]} >> sh;
            if (h < 0 && rg[n][0] && a64 == b64) h = n;                  // R3 R4
        end
        if (h < 0) begin e_rd = 0; e_wr = 0; e_f = 2'b10; return; end  // R6
        w = (acc == 2'b00) ? iperm : dperm;                             // R7
        c = 4'((w >> (4 * h)) & 32'hf);
        {pr, pw, ur, uw} = 4'b0000;
        case (c)                                                         // R8
            4'd1: {pr, pw, ur, uw} = 4'b1100;
            4'd2: {pr, pw, ur, uw} = 4'b1110;
            4'd3: {pr, pw, ur, uw} = 4'b1111;
            4'd5: {pr, pw, ur, uw} = 4'b1000;
            4'd6: {pr, pw, ur, uw} = 4'b1010;
            default: ;
        endcase
        e_rd = priv ? pr : ur;
        e_wr = priv ? pw : uw;
        need = acc[1] ? e_wr : e_rd;
        e_f  = need ? 2'b00 : 2'b01;                                     // R9 R10
    endtask

    task automatic check(input string tag);
        logic e_rd, e_wr;
        logic [1:0] e_f;
        model(e_rd, e_wr, e_f);
        checks++;
        if (paddr !== addr) begin
            failures++;
            $display("FAIL R2 (%s) paddr actual=%h expected=%h", tag, paddr, addr);
        end else if ({rd_ok, wr_ok, fault} !== {e_rd, e_wr, e_f}) begin
            failures++;
            $display("FAIL %s addr=%h acc=%0d priv=%0d actual rd=%b wr=%b f=%b expected rd=%b wr=%b f=%b",
                     tag, addr, acc, priv, rd_ok, wr_ok, fault, e_rd, e_wr, e_f);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [1:0] k, input logic p, input string tag);
        @(negedge clk);
        addr = a; acc = k; priv = p;
        #5;
        check(tag);
    endtask

    task automatic clear_regions();
        for (int n = 0; n < NR; n++) rg[n] = 32'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_regions();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R1: disabled state passes everything
        apply(32'h0, 2'b10, 1'b0, "R1");
        dperm = '0; iperm = '0;
        for (int k = 0; k < 4; k++) apply(32'hdead_beef, 2'(k), 1'b0, "R1");

        // R8 R9 R10 R7: every code, privilege and access kind in region 3
        en = 1'b1;
        clear_regions();
        rg[3] = 32'h4000_0000 | (32'd12 << 1) | 32'd1;   // 8 KiB
        for (int c = 0; c < 16; c++) begin
            dperm = 32'(c) << 12;
            iperm = 32'(15 - c) << 12;
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 4; k++) begin
                    apply(32'h4000_1234, 2'(k), 1'(p), "R8");
                    apply(32'h4000_0000, 2'(k), 1'(p), "R7");
                end
        end

        // R3 R6: region edges
        dperm = 32'h0000_3000; iperm = 32'h0000_6000;
        apply(32'h3fff_ffff, 2'b01, 1'b1, "R6");
        apply(32'h4000_1fff, 2'b01, 1'b1, "R3");
        apply(32'h4000_2000, 2'b10, 1'b1, "R6");
        rg[3][0] = 1'b0;
        apply(32'h4000_0010, 2'b01, 1'b1, "R3");

        // R3: smallest region, size code 0 covers two bytes
        clear_regions();
        rg[1] = 32'h0000_1000 | 32'd1;
        dperm = 32'h0000_0030;
        for (int i = 0; i < 6; i++) apply(32'h0000_0ffe + 32'(i), 2'b10, 1'b0, "R3");

        // R4: size code 31 spans everything
        clear_regions();
        rg[0] = 32'hffff_ffc0 | (32'd31 << 1) | 32'd1;
        dperm = 32'h0000_0003; iperm = 32'h0000_0006;
        for (int i = 0; i < 40; i++) begin
            lfsr = nxt(lfsr);
            apply(lfsr, 2'(i), 1'(i >> 2), "R4");
        end

        // R5: nested overlapping map, generated addresses
        clear_regions();
        for (int n = 0; n < NR; n++)
            rg[n] = 32'h8000_0000 | (32'(28 - 3 * n) << 1) | 32'd1;
        dperm = 32'h6532_1653; iperm = 32'h3216_5321;
        for (int i = 0; i < 1500; i++) begin
            lfsr = nxt(lfsr);
            apply({lfsr[31], 4'b0, lfsr[27:1] & (32'h7ff_ffff >> lfsr[4:0])}, lfsr[6:5], lfsr[7], "R5");
        end

        // R5 R2: generated configurations
        for (int i = 0; i < 2000; i++) begin
            for (int n = 0; n < NR; n++) begin
                lfsr = nxt(lfsr);
                rg[n] = {lfsr[31:6], lfsr[5:4] | 2'b10, lfsr[3:0]};
            end
            lfsr = nxt(lfsr); dperm = lfsr;
            lfsr = nxt(lfsr); iperm = lfsr;
            lfsr = nxt(lfsr);
            en = (i % 10) != 0;
            apply(lfsr, lfsr[9:8], lfsr[10], en ? "R5" : "R1");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule